// File: doc/BRIEF.md
# Interrupt-Return Stack Unwinder

This block carries out the return-from-interrupt instruction for an 8-bit processor core. The core has two accumulators, two 16-bit index registers and a condition-code register. When the decoder presents opcode 0x3B together with a start strobe, the unwinder captures the current stack pointer and condition codes. It then reads nine bytes from a byte-wide stack, each at a pre-incremented stack address, and sends the rebuilt register values to the register file over a single write bus, one destination at a time. The program-counter load is the last write, and it lands in the final cycle of a fixed 12-cycle instruction.

The condition-code byte is restored with one protection rule. The non-maskable-interrupt mask bit (bit 6 of the condition codes) can be cleared by the restore but can never be set by it. Every other flag takes the popped value as it is.

The stack read port is synchronous: a byte requested in one cycle comes back on `mem_rdata` in the next. The stack pointer seen on `sp_out` tracks each pop and wraps modulo 2^16.

Top module: `irq_return_unwinder`

## Requirements
- R1: A launch happens only when `start` is high, `opcode` equals 0x3B and the block is idle. A start with any other opcode, or a start while `busy` is high, causes no stack read, no register write and no change to a sequence already running.
- R2: Once launched, `busy` stays high for exactly 12 cycles. `done` is high only in the twelfth of them.
- R3: The nine stack reads take place in cycles 2 to 10 of the instruction. Read k (k = 1..9) uses address SP+k modulo 2^16, where SP is `sp_in` at launch. Read data is taken from `mem_rdata` in the cycle after the request.
- R4: `sp_out` is loaded with SP at launch. It rises by one (mod 2^16) after every read and ends at SP+9.
- R5: The write bus restores registers in the order condition codes, B, A, X, Y, PC. The `wr_dest` codes are 1 for the condition codes, 2 for B, 3 for A, 4 for X, 5 for Y and 6 for PC. These writes appear in cycles 4, 5, 6, 8, 10 and 12, and `wr_en` is low in every other cycle.
- R6: Each 16-bit value is popped high byte first: the byte at the lower address is bits 15:8 of `wr_data`. Eight-bit writes place the byte in bits 7:0, with bits 15:8 zero.
- R7: Every condition-code bit except bit 6 is written with the popped value.
- R8: Bit 6 of the written condition codes equals the popped bit ANDed with bit 6 of `ccr_in` captured at launch, so it can go from 1 to 0 but never from 0 to 1.
- R9: The PC write is the last write of the instruction and happens in the cycle where `done` is high.
- R10: After reset, `busy`, `done`, `mem_rd` and `wr_en` are low and `sp_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Decoder strobe requesting execution |
| opcode | input | 8 | Opcode presented with the strobe |
| sp_in | input | 16 | Stack pointer captured at launch |
| ccr_in | input | 8 | Current condition codes captured at launch |
| mem_rd | output | 1 | Stack read request |
| mem_addr | output | 16 | Stack read address |
| mem_rdata | input | 8 | Stack read data, valid the cycle after the request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| sp_out | output | 16 | Current stack pointer |
| wr_en | output | 1 | Register write strobe |
| wr_dest | output | 3 | Write destination code |
| wr_data | output | 16 | Write data |

## Verification
The bench sweeps all 256 popped condition-code bytes, each with the prior mask bit clear and set. This pairs every popped value of bit 6 with both prior states and shows that the protection rule touches only that bit. Stack pointers are spread across the address space, with a cluster just below 0xFFFF, so the wrap is exercised on both the read addresses and the final pointer. Frame bytes differ from one another, so a swapped pop order or a swapped high/low byte shows up as a wrong value in a particular cycle. Separate runs try a wrong opcode and a second start in the middle of a sequence; both must leave the outputs unchanged.

// File: rtl/rti_pkg.sv
package rti_pkg;

  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_CCR  = 3'd1,
    DST_ACCB = 3'd2,
    DST_ACCA = 3'd3,
    DST_IX   = 3'd4,
    DST_IY   = 3'd5,
    DST_PC   = 3'd6
  } rti_dest_e;

  localparam int unsigned FRAME_BYTES = 9;

  // Mask bit may fall but never rise during the restore.
  function automatic logic [7:0] restore_ccr(input logic [7:0] prior,
                                             input logic [7:0] popped,
                                             input int unsigned xbit);
    logic [7:0] r;
    r       = popped;
    r[xbit] = popped[xbit] & prior[xbit];
    return r;
  endfunction

  // Destination completed by frame byte idx (NONE for high halves).
  function automatic rti_dest_e dest_of_byte(input int unsigned idx);
    case (idx)
      0:       return DST_CCR;
      1:       return DST_ACCB;
      2:       return DST_ACCA;
      4:       return DST_IX;
      6:       return DST_IY;
      8:       return DST_PC;
      default: return DST_NONE;
    endcase
  endfunction

  function automatic logic is_high_byte(input int unsigned idx);
    return (idx == 3) || (idx == 5) || (idx == 7);
  endfunction

  function automatic logic is_wide(input rti_dest_e d);
    return (d == DST_IX) || (d == DST_IY) || (d == DST_PC);
  endfunction

endpackage

// File: rtl/rti_step_ctrl.sv
module rti_step_ctrl #(
  parameter int TOTAL_CYCLES = 12,
  parameter int NUM_BYTES    = 9,
  parameter int FIRST_READ   = 1,
  localparam int IDX_W       = $clog2(NUM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             busy,
  output logic             done,
  output logic             rd_fire,
  output logic             rx_fire,
  output logic [IDX_W-1:0] rx_index
);
  localparam int STEP_W = $clog2(TOTAL_CYCLES);
  localparam logic [STEP_W-1:0] RD_LO = STEP_W'(FIRST_READ);
  localparam logic [STEP_W-1:0] RD_HI = STEP_W'(FIRST_READ + NUM_BYTES - 1);
  localparam logic [STEP_W-1:0] RX_LO = STEP_W'(FIRST_READ + 1);
  localparam logic [STEP_W-1:0] RX_HI = STEP_W'(FIRST_READ + NUM_BYTES);
  localparam logic [STEP_W-1:0] LAST  = STEP_W'(TOTAL_CYCLES - 1);

  logic [STEP_W-1:0] step_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q) begin
      if (step_q == LAST) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && (step_q == LAST);
  assign rd_fire  = busy_q && (step_q >= RD_LO) && (step_q <= RD_HI);
  assign rx_fire  = busy_q && (step_q >= RX_LO) && (step_q <= RX_HI);
  assign rx_index = IDX_W'(step_q - RX_LO);

  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_launch_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy_q);

  assert_rx_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rx_fire);

endmodule

// File: rtl/rti_stack_addr.sv
module rti_stack_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] sp_init,
  input  logic              advance,
  output logic [ADDR_W-1:0] sp_now,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= '0;
    else if (launch)  sp_q <= sp_init;
    else if (advance) sp_q <= sp_q + 1'b1;
  end

  assign sp_now  = sp_q;
  assign rd_addr = sp_q + 1'b1;

  assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> sp_now == ADDR_W'($past(sp_now) + 1'b1));

  assert_sp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !launch) |=> $stable(sp_now));

endmodule

// File: rtl/rti_assemble.sv
module rti_assemble
  import rti_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int XMASK_BIT = 6,
  parameter int IDX_W     = 4,
  localparam int WORD_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] ccr_prior_in,
  input  logic              rx_fire,
  input  logic [IDX_W-1:0]  rx_index,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              wr_en,
  output rti_dest_e         wr_dest,
  output logic [WORD_W-1:0] wr_data
);
  logic [DATA_W-1:0] ccr_prior_q;
  logic [DATA_W-1:0] hi_q;
  rti_dest_e         dest_c;
  logic [WORD_W-1:0] data_c;

  always_comb begin
    dest_c = dest_of_byte(int'(rx_index));
    if (dest_c == DST_CCR)
      data_c = {{DATA_W{1'b0}}, restore_ccr(ccr_prior_q, rx_byte, XMASK_BIT)};
    else if (is_wide(dest_c))
      data_c = {hi_q, rx_byte};
    else
      data_c = {{DATA_W{1'b0}}, rx_byte};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_prior_q <= '0;
      hi_q        <= '0;
      wr_en       <= 1'b0;
      wr_dest     <= DST_NONE;
      wr_data     <= '0;
    end else begin
      if (launch) ccr_prior_q <= ccr_prior_in;
      if (rx_fire && is_high_byte(int'(rx_index))) hi_q <= rx_byte;
      wr_en   <= rx_fire && (dest_c != DST_NONE);
      wr_dest <= rx_fire ? dest_c : DST_NONE;
      wr_data <= rx_fire ? data_c : '0;
    end
  end

  assert_xmask_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dest == DST_CCR && !ccr_prior_q[XMASK_BIT]) |-> !wr_data[XMASK_BIT]);

  assert_write_follows_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rx_fire));

endmodule

// File: rtl/irq_return_unwinder.sv
module irq_return_unwinder
  import rti_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          TOTAL_CYCLES = 12,
  parameter int          XMASK_BIT    = 6,
  parameter logic [7:0]  RTI_OPCODE   = 8'h3B,
  localparam int         WORD_W       = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [DATA_W-1:0] ccr_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp_out,
  output logic              wr_en,
  output logic [2:0]        wr_dest,
  output logic [WORD_W-1:0] wr_data
);
  localparam int NUM_BYTES  = FRAME_BYTES;
  localparam int FIRST_READ = 1;
  localparam int IDX_W      = $clog2(NUM_BYTES);

  logic             launch;
  logic             rd_fire;
  logic             rx_fire;
  logic [IDX_W-1:0] rx_index;
  rti_dest_e        dest_e;

  assign launch = start && (opcode == RTI_OPCODE) && !busy;

  rti_step_ctrl #(
    .TOTAL_CYCLES(TOTAL_CYCLES),
    .NUM_BYTES   (NUM_BYTES),
    .FIRST_READ  (FIRST_READ)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .busy    (busy),
    .done    (done),
    .rd_fire (rd_fire),
    .rx_fire (rx_fire),
    .rx_index(rx_index)
  );

  rti_stack_addr #(.ADDR_W(ADDR_W)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .sp_init(sp_in),
    .advance(rd_fire),
    .sp_now (sp_out),
    .rd_addr(mem_addr)
  );

  rti_assemble #(
    .DATA_W   (DATA_W),
    .XMASK_BIT(XMASK_BIT),
    .IDX_W    (IDX_W)
  ) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .ccr_prior_in(ccr_in),
    .rx_fire     (rx_fire),
    .rx_index    (rx_index),
    .rx_byte     (mem_rdata),
    .wr_en       (wr_en),
    .wr_dest     (dest_e),
    .wr_data     (wr_data)
  );

  assign mem_rd  = rd_fire;
  assign wr_dest = dest_e;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !wr_en));

  assert_addr_preinc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr == ADDR_W'(sp_out + 1'b1));

  generate
    if (TOTAL_CYCLES == NUM_BYTES + 3) begin : g_tight
      assert_pc_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_en && wr_dest == 3'(DST_PC)));
    end
  endgenerate

endmodule

// File: tb/irq_return_unwinder_bench.sv
`timescale 1ns/1ps
module irq_return_unwinder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] sp_in = 16'h0;
  logic [7:0]  ccr_in = 8'h0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h0;
  logic        busy, done, wr_en;
  logic [15:0] sp_out, wr_data;
  logic [2:0]  wr_dest;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  frame [9];
  logic [15:0] frame_sp = 16'h0;

  always #2 clk = ~clk;

  irq_return_unwinder u_irq_return_unwinder (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .sp_in(sp_in), .ccr_in(ccr_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out),
    .wr_en(wr_en), .wr_dest(wr_dest), .wr_data(wr_data)
  );

  function automatic logic [7:0] peek(input logic [15:0] a);
    logic [15:0] off;
    off = a - frame_sp - 16'd1;
    return (off < 16'd9) ? frame[off[3:0]] : 8'hEE;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= peek(mem_addr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_rti(input logic [15:0] sp, input logic [7:0] prior, input bit poke);
    logic [7:0]  exp_ccr;
    logic        e_en;
    logic [2:0]  e_dst;
    logic [15:0] e_dat;
    exp_ccr  = (frame[0] & 8'hBF) | (frame[0] & prior & 8'h40);
    frame_sp = sp;
    @(negedge clk);
    start = 1'b1; opcode = 8'h3B; sp_in = sp; ccr_in = prior;
    @(negedge clk);
    start = 1'b0; opcode = 8'h12; sp_in = ~sp; ccr_in = ~prior;
    for (int cyc = 0; cyc < 12; cyc++) begin
      if (poke && cyc == 5) begin start = 1'b1; opcode = 8'h3B; end
      if (poke && cyc == 6) start = 1'b0;
      check(busy == 1'b1, "R2", "busy", busy, 1);
      check(done == (cyc == 11), "R2", "done", done, (cyc == 11));
      check(mem_rd == (cyc >= 1 && cyc <= 9), "R3", "mem_rd", mem_rd, (cyc >= 1 && cyc <= 9));
      if (cyc >= 1 && cyc <= 9)
        check(mem_addr == 16'(sp + 16'(cyc)), "R3", "mem_addr", mem_addr, 16'(sp + 16'(cyc)));
      e_en = 1'b1;
      case (cyc)
        3:  begin e_dst = 3'd1; e_dat = {8'h00, exp_ccr}; end
        4:  begin e_dst = 3'd2; e_dat = {8'h00, frame[1]}; end
        5:  begin e_dst = 3'd3; e_dat = {8'h00, frame[2]}; end
        7:  begin e_dst = 3'd4; e_dat = {frame[3], frame[4]}; end
        9:  begin e_dst = 3'd5; e_dat = {frame[5], frame[6]}; end
        11: begin e_dst = 3'd6; e_dat = {frame[7], frame[8]}; end
        default: begin e_en = 1'b0; e_dst = 3'd0; e_dat = 16'h0; end
      endcase
      check(wr_en == e_en, "R5", "wr_en", wr_en, e_en);
      if (e_en) begin
        check(wr_dest == e_dst, "R5", "wr_dest", wr_dest, e_dst);
        if (cyc == 3) begin
          check(wr_data[7:0] == exp_ccr, "R8", "ccr", wr_data, exp_ccr);
          check((wr_data[7:0] & 8'hBF) == (frame[0] & 8'hBF), "R7", "ccr others",
                wr_data & 16'h00BF, frame[0] & 8'hBF);
        end else begin
          check(wr_data == e_dat, (cyc == 11) ? "R9" : "R6", "wr_data", wr_data, e_dat);
        end
      end
      @(negedge clk);
    end
    check(busy == 1'b0, "R2", "busy after", busy, 0);
    check(sp_out == 16'(sp + 16'd9), "R4", "sp_out final", sp_out, 16'(sp + 16'd9));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 0, "R10", "busy", busy, 0);
    check(done == 0, "R10", "done", done, 0);
    check(mem_rd == 0, "R10", "mem_rd", mem_rd, 0);
    check(wr_en == 0, "R10", "wr_en", wr_en, 0);
    check(sp_out == 0, "R10", "sp_out", sp_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: wrong opcode is ignored
    start = 1'b1; opcode = 8'h3A; sp_in = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    check(busy == 0, "R1", "busy on wrong opcode", busy, 0);
    check(mem_rd == 0, "R1", "mem_rd on wrong opcode", mem_rd, 0);
    check(sp_out == 0, "R1", "sp_out on wrong opcode", sp_out, 0);
    @(negedge clk);
    check(wr_en == 0, "R1", "wr_en on wrong opcode", wr_en, 0);

    // Sweep popped ccr and prior mask bit
    for (int p = 0; p < 256; p++) begin
      for (int xp = 0; xp < 2; xp++) begin
        logic [15:0] sp;
        logic [7:0]  prior;
        frame[0] = 8'(p);
        for (int i = 1; i < 9; i++) frame[i] = 8'(p * 7 + i * 29 + xp * 3 + 1);
        sp    = (p % 3 == 0) ? (16'hFFF0 + 16'(p % 16)) : 16'(p * 251);
        prior = (xp != 0) ? (8'(~p) | 8'h40) : (8'(~p) & 8'hBF);
        run_rti(sp, prior, 1'b0);
      end
    end

    // R1: second start mid-sequence is ignored
    for (int i = 0; i < 9; i++) frame[i] = 8'(8'hA0 + i * 17);
    run_rti(16'hFFFB, 8'h40, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule